// File: doc/BRIEF.md
# Priority Watermark Buffer Admission

This block manages the receive-side packet buffer pool of one fabric port. It does not hold payload. It tracks which of the shared buffer slots are in use, how many packets of each priority are stored, and the relative age of each stored packet. When a packet arrives with a 2-bit priority, the block decides in the same cycle whether to accept it into a free slot or to tell the link to retry it. It also presents the stored packet that should leave next, which is always the highest priority and, within one priority, the oldest.

Two admission policies are available through a static mode pin. In watermark mode, each priority needs a minimum number of free buffers before it may take one. Lower priorities are therefore turned away early, and the top priority can use the entire pool. In reserved mode, every priority keeps one private buffer and the rest of the pool is shared. Both policies rely on responses carrying a higher priority than the requests that caused them, so responses can always find room and the fabric cannot deadlock.

The output side takes the presented packet with a release strobe. The freed slot counts as available to an arrival in the same cycle.

Top module: `wmb_buf_admit`

## Requirements
- R1: While `rst_ni` is low and before the first clock edge after it rises, `free_cnt_o` is 8 and `sel_valid_o` is 0.
- R2: In any cycle with `arr_valid_i` high, exactly one of `accept_o` and `retry_o` is high, decided combinationally in that cycle. With `arr_valid_i` low, both are low.
- R3: With `mode_i`=0 (watermark), a packet of priority p (0 lowest, 3 highest) is accepted only if the effective free count is greater than 3-p. So priority 0 needs more than 3 free, priority 1 more than 2, priority 2 more than 1, and priority 3 more than 0.
- R4: With `mode_i`=1 (reserved), the 8 buffers are split into one private buffer per priority plus 4 shared buffers. A packet of priority p is accepted if no priority-p packet is stored, or if fewer than 4 shared buffers are in use. Shared use is the sum over priorities of (stored count − 1) for every priority with a non-zero count.
- R5: A release that takes effect in the same cycle as an arrival is applied first: its buffer and its priority count are already free when admission is evaluated.
- R6: `free_cnt_o` changes on the clock edge after the strobes: it goes up by 1 for an effective release and down by 1 for an accept.
- R7: `sel_valid_o` is high whenever any packet is stored. `sel_prio_o` is then the highest priority among the stored packets.
- R8: Among stored packets of the priority shown on `sel_prio_o`, `sel_slot_o` names the one that was accepted earliest.
- R9: A retried packet changes no state: the free count, the per-priority counts and the selection are unchanged.
- R10: `rel_i` while `sel_valid_o` is low has no effect.
- R11: An accepted packet takes the lowest-numbered slot (0..7) that is empty after the same-cycle release, so a slot released in that cycle can be reused at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Admission policy: 0 watermark, 1 reserved; static outside reset |
| arr_valid_i | input | 1 | Packet arrival strobe |
| arr_prio_i | input | 2 | Priority of the arriving packet, 3 highest |
| rel_i | input | 1 | Output side takes the selected packet and frees its buffer |
| accept_o | output | 1 | Arrival admitted this cycle |
| retry_o | output | 1 | Arrival refused this cycle, to be retried |
| free_cnt_o | output | 4 | Number of free buffers |
| sel_valid_o | output | 1 | A stored packet is ready to leave |
| sel_prio_o | output | 2 | Priority of the packet that leaves next |
| sel_slot_o | output | 3 | Slot tag of the packet that leaves next |

## Verification
The invariants on the assertions depend on `mode_i` holding one value between resets. The bound on each priority band and the private-buffer reserve are only guaranteed under the policy that filled the pool. The bench therefore changes the mode only while reset is held low. The assertions also take it that `rel_i` is meaningful only against the presented selection. The bench drives it freely, including while the pool is empty, to show that such strobes are ignored. Stimulus covers every pool fill level from 0 to 8 under two fill patterns, every arriving priority with and without a same-cycle release, and long pseudo-random runs in both modes. The expected outcome of each run comes from an arithmetic model of counts and arrival order.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  typedef enum logic {
    ADM_WATERMARK = 1'b0,
    ADM_RESERVED  = 1'b1
  } adm_mode_e;
endpackage

// File: rtl/wmb_admit.sv
module wmb_admit
  import wmb_pkg::*;
#(
  parameter int unsigned NUM_BUF  = 8,
  parameter int unsigned NUM_PRIO = 4,
  parameter int unsigned WM_STEP  = 1,
  localparam int unsigned CW = $clog2(NUM_BUF + 1),
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  adm_mode_e                     mode_i,
  input  logic                          arr_valid_i,
  input  logic [PW-1:0]                 arr_prio_i,
  input  logic                          rel_fire_i,
  input  logic [PW-1:0]                 rel_prio_i,
  output logic                          accept_o,
  output logic                          retry_o,
  output logic [CW-1:0]                 free_cnt_o,
  output logic [NUM_PRIO-1:0][CW-1:0]   prio_cnt_o
);
  localparam int unsigned SHARED = NUM_BUF - NUM_PRIO;

  logic [CW-1:0]               free_q, free_eff, shared_used;
  logic [NUM_PRIO-1:0][CW-1:0] cnt_q, cnt_eff;
  logic                        ok_wm, ok_rs;

  function automatic logic [CW-1:0] wmark(input logic [PW-1:0] p);
    return CW'((NUM_PRIO - 1 - int'(p)) * WM_STEP);
  endfunction

  // release is applied before admission
  always_comb begin
    free_eff    = free_q + CW'(rel_fire_i);
    shared_used = '0;
    for (int p = 0; p < NUM_PRIO; p++) begin
      cnt_eff[p] = cnt_q[p] - CW'(rel_fire_i && rel_prio_i == PW'(p));
      if (cnt_eff[p] != '0) shared_used = shared_used + cnt_eff[p] - CW'(1);
    end
    ok_wm    = free_eff > wmark(arr_prio_i);
    ok_rs    = (free_eff != '0) &&
               ((cnt_eff[arr_prio_i] == '0) || (shared_used < CW'(SHARED)));
    accept_o = arr_valid_i && ((mode_i == ADM_RESERVED) ? ok_rs : ok_wm);
    retry_o  = arr_valid_i && !accept_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= CW'(NUM_BUF);
      cnt_q  <= '0;
    end else begin
      free_q <= free_q + CW'(rel_fire_i) - CW'(accept_o);
      for (int p = 0; p < NUM_PRIO; p++)
        cnt_q[p] <= cnt_q[p] + CW'(accept_o && arr_prio_i == PW'(p))
                             - CW'(rel_fire_i && rel_prio_i == PW'(p));
    end
  end

  assign free_cnt_o = free_q;
  assign prio_cnt_o = cnt_q;

  // checker-side sums
  logic [NUM_PRIO-1:0][CW-1:0] band_sum;
  logic [CW-1:0]               empty_prios;
  always_comb begin
    empty_prios = '0;
    for (int p = 0; p < NUM_PRIO; p++) begin
      band_sum[p] = (p == 0) ? cnt_q[0] : band_sum[p-1] + cnt_q[p];
      if (cnt_q[p] == '0) empty_prios = empty_prios + CW'(1);
    end
  end

  a_r6_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CW'(NUM_BUF));

  a_r9_retry_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o && !rel_fire_i) |=> ($stable(free_q) && $stable(cnt_q)));

  a_r4_reserve_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ADM_RESERVED) |-> (free_q >= empty_prios));

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_band
    a_r3_band_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == ADM_WATERMARK) |->
        (band_sum[p] <= CW'(NUM_BUF) - wmark(PW'(p))));
  end
endmodule

// File: rtl/wmb_slots.sv
module wmb_slots #(
  parameter int unsigned NUM_BUF  = 8,
  parameter int unsigned NUM_PRIO = 4,
  localparam int unsigned SW = $clog2(NUM_BUF),
  localparam int unsigned CW = $clog2(NUM_BUF + 1),
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [PW-1:0]      alloc_prio_i,
  input  logic               rel_i,
  output logic               sel_valid_o,
  output logic [PW-1:0]      sel_prio_o,
  output logic [SW-1:0]      sel_slot_o,
  output logic [NUM_BUF-1:0] occ_o
);
  logic [NUM_BUF-1:0]         vld_q;
  logic [NUM_BUF-1:0][PW-1:0] prio_q;
  logic [NUM_BUF-1:0][SW-1:0] rank_q;   // 0 = oldest stored packet

  logic          best_v;
  logic [PW-1:0] best_p;
  logic [SW-1:0] best_r, best_i, alloc_idx, new_rank;
  logic [CW-1:0] occ;
  logic          alloc_found;

  always_comb begin
    best_v = 1'b0;
    best_p = '0;
    best_r = '0;
    best_i = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (vld_q[i] && (!best_v || prio_q[i] > best_p ||
                       (prio_q[i] == best_p && rank_q[i] < best_r))) begin
        best_v = 1'b1;
        best_p = prio_q[i];
        best_r = rank_q[i];
        best_i = SW'(i);
      end
    end
  end

  always_comb begin
    occ         = '0;
    alloc_idx   = '0;
    alloc_found = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      occ = occ + CW'(vld_q[i]);
      if (!alloc_found && (!vld_q[i] || (rel_i && best_i == SW'(i)))) begin
        alloc_idx   = SW'(i);
        alloc_found = 1'b1;
      end
    end
    new_rank = SW'(occ - CW'(rel_i));
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]  <= 1'b0;
        prio_q[i] <= '0;
        rank_q[i] <= '0;
      end else if (alloc_i && alloc_idx == SW'(i)) begin
        vld_q[i]  <= 1'b1;
        prio_q[i] <= alloc_prio_i;
        rank_q[i] <= new_rank;
      end else if (rel_i && best_i == SW'(i)) begin
        vld_q[i]  <= 1'b0;
      end else if (rel_i && vld_q[i] && rank_q[i] > best_r) begin
        rank_q[i] <= rank_q[i] - SW'(1);
      end
    end
  end

  assign sel_valid_o = best_v;
  assign sel_prio_o  = best_p;
  assign sel_slot_o  = best_i;
  assign occ_o       = vld_q;

  a_r11_slot_available: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> alloc_found);

  a_r10_release_needs_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> best_v);
endmodule

// File: rtl/wmb_buf_admit.sv
module wmb_buf_admit
  import wmb_pkg::*;
#(
  parameter int unsigned NUM_BUF  = 8,
  parameter int unsigned NUM_PRIO = 4,
  parameter int unsigned WM_STEP  = 1,
  localparam int unsigned CW = $clog2(NUM_BUF + 1),
  localparam int unsigned SW = $clog2(NUM_BUF),
  localparam int unsigned PW = $clog2(NUM_PRIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          arr_valid_i,
  input  logic [PW-1:0] arr_prio_i,
  input  logic          rel_i,
  output logic          accept_o,
  output logic          retry_o,
  output logic [CW-1:0] free_cnt_o,
  output logic          sel_valid_o,
  output logic [PW-1:0] sel_prio_o,
  output logic [SW-1:0] sel_slot_o
);
  logic                        rel_fire;
  logic [NUM_PRIO-1:0][CW-1:0] prio_cnt;
  logic [NUM_BUF-1:0]          occ;

  assign rel_fire = rel_i && sel_valid_o;

  wmb_admit #(.NUM_BUF(NUM_BUF), .NUM_PRIO(NUM_PRIO), .WM_STEP(WM_STEP)) u_admit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (adm_mode_e'(mode_i)),
    .arr_valid_i (arr_valid_i),
    .arr_prio_i  (arr_prio_i),
    .rel_fire_i  (rel_fire),
    .rel_prio_i  (sel_prio_o),
    .accept_o    (accept_o),
    .retry_o     (retry_o),
    .free_cnt_o  (free_cnt_o),
    .prio_cnt_o  (prio_cnt)
  );

  wmb_slots #(.NUM_BUF(NUM_BUF), .NUM_PRIO(NUM_PRIO)) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (accept_o),
    .alloc_prio_i (arr_prio_i),
    .rel_i        (rel_fire),
    .sel_valid_o  (sel_valid_o),
    .sel_prio_o   (sel_prio_o),
    .sel_slot_o   (sel_slot_o),
    .occ_o        (occ)
  );

  a_r6_occupancy_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ) == NUM_BUF - int'(free_cnt_o));

  a_r10_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !sel_valid_o && !arr_valid_i) |=> $stable(free_cnt_o));

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_order
    a_r7_no_higher_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_o && sel_prio_o < PW'(p)) |-> (prio_cnt[p] == '0));
  end
endmodule

// File: tb/tb_wmb_buf_admit.sv
`timescale 1ns/1ps
module tb_wmb_buf_admit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode = 1'b0;
  logic       arr_valid = 1'b0;
  logic [1:0] arr_prio = '0;
  logic       rel = 1'b0;
  logic       accept_o, retry_o, sel_valid_o;
  logic [3:0] free_cnt_o;
  logic [1:0] sel_prio_o;
  logic [2:0] sel_slot_o;

  always #2.5 clk = ~clk;

  wmb_buf_admit dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .arr_valid_i(arr_valid),
    .arr_prio_i(arr_prio), .rel_i(rel), .accept_o(accept_o), .retry_o(retry_o),
    .free_cnt_o(free_cnt_o), .sel_valid_o(sel_valid_o), .sel_prio_o(sel_prio_o),
    .sel_slot_o(sel_slot_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  bit m_vld [8];
  int m_prio [8];
  int m_seq [8];
  int seq = 0;
  string last_tag = "R6";
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_free();
    int f = 8;
    for (int i = 0; i < 8; i++) if (m_vld[i]) f--;
    return f;
  endfunction

  task automatic do_reset(bit md);
    @(negedge clk);
    rst_ni = 1'b0; mode = md; arr_valid = 1'b0; rel = 1'b0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    seq = 0; last_tag = "R6";
    #1;
    chk("R1", free_cnt_o, 8);
    chk("R1", sel_valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1", free_cnt_o, 8);
    chk("R1", sel_valid_o, 0);
  endtask

  task automatic step(bit a, int p, bit r);
    bit sv = 0, rf, acc;
    int sp = 0, ss = 0, fe, shared, slot;
    int ce [4];
    string tag;
    @(negedge clk);
    arr_valid = a; arr_prio = 2'(p); rel = r;
    #1;
    chk(last_tag, free_cnt_o, m_free());
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && (!sv || m_prio[i] > sp || (m_prio[i] == sp && m_seq[i] < m_seq[ss]))) begin
        sv = 1; sp = m_prio[i]; ss = i;
      end
    chk("R7", sel_valid_o, sv);
    if (sv) begin
      chk("R7", sel_prio_o, sp);
      chk("R8,R11", sel_slot_o, ss);
    end
    rf = r && sv;
    fe = m_free() + (rf ? 1 : 0);
    for (int q = 0; q < 4; q++) ce[q] = 0;
    for (int i = 0; i < 8; i++) if (m_vld[i] && !(rf && i == ss)) ce[m_prio[i]]++;
    shared = 0;
    for (int q = 0; q < 4; q++) if (ce[q] > 0) shared += ce[q] - 1;
    if (mode) acc = (fe > 0) && (ce[p] == 0 || shared < 4);
    else      acc = fe > 3 - p;
    tag = mode ? "R4" : "R3";
    if (a && rf) tag = "R5";
    chk(tag, accept_o, (a && acc) ? 1 : 0);
    chk("R2", retry_o, (a && !acc) ? 1 : 0);
    @(posedge clk);
    if (rf) m_vld[ss] = 0;
    if (a && acc) begin
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_vld[i]) slot = i;
      m_vld[slot] = 1; m_prio[slot] = p; m_seq[slot] = seq; seq++;
    end
    if (a && !acc && !rf) last_tag = "R9";
    else if (r && !sv) last_tag = "R10";
    else last_tag = "R6";
  endtask

  initial begin
    // sweep: mode x fill pattern x fill level x probe priority x same-cycle release
    for (int md = 0; md < 2; md++)
      for (int pat = 0; pat < 2; pat++)
        for (int n = 0; n <= 8; n++)
          for (int p = 0; p < 4; p++)
            for (int r = 0; r < 2; r++) begin
              do_reset(md[0]);
              step(0, 0, 1);  // release on empty pool: R10
              for (int k = 0; k < n; k++) step(1, pat ? (k * 3) % 4 : 3, 0);
              step(1, p, r[0]);
              step(0, 0, 0);
              step(1, p, 0);  // repeat probe after state settles
              step(0, 0, 0);
            end
    // pseudo-random traffic in both modes, alternating fill and drain bias
    for (int md = 0; md < 2; md++) begin
      do_reset(md[0]);
      for (int t = 0; t < 4000; t++) begin
        bit ra;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        ra = ((t / 400) % 2 == 0) ? (lfsr[4] & lfsr[5]) : (lfsr[4] | lfsr[5]);
        step(lfsr[0] | lfsr[1], int'(lfsr[3:2]), ra);
      end
      step(0, 0, 0);
    end
    do_reset(1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule